// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Condition Status Word

This block is the arithmetic core of a small eight-bit processor datapath. A combinational result is formed each cycle from the accumulator, a second operand and an operation code. The second operand may be a scratchpad byte, a memory byte or an immediate; the surrounding datapath picks it. On the next rising clock edge a five-flag status word is updated. The stored carry feeds back into the add-carry operation.

How the flags change depends on the class of the operation:
- Arithmetic operations write all four condition flags.
- Logic operations and left shifts clear overflow and carry.
- Right shifts also pin the sign flag high.
- Clearing the accumulator leaves the flags alone.

Two side inputs set and clear the interrupt-control bit. Operand routing and instruction decode stay in the datapath around this block.

Top module: `alu_status8`

## Requirements
- R1: The status word is 8 bits: bit 4 interrupt-control, bit 3 overflow (O), bit 2 zero (Z), bit 1 carry (C), bit 0 sign (S). Bits 7:5 are always 0. Reset (rst_ni low) clears the word to 0x00. The status word changes on the rising clock edge at which an operation is presented, and result_o is combinational in the same cycle.
- R2: Add (op 1) gives acc+opnd, increment (op 2) gives acc+1, and link (op 3) gives acc plus the stored carry. For these, C is the carry out of bit 7, and O is the carry into bit 7 XOR the carry out of bit 7.
- R3: Every flag-writing operation sets Z when its 8-bit flag value is 0 and clears it otherwise. It sets S to the inverse of bit 7 of that value, unless R6 forces S.
- R4: Compare (op 4) takes its flags from the 9-bit sum opnd + ~acc + 1, and result_o equals acc. Decrement (op 5) outputs opnd-1 and takes its flags from opnd + 0xFF. Both ops set C and O as in R2.
- R5: AND (op 8), OR (op 9), XOR (op 10) of acc with opnd, complement (op 11) of acc, shift left by 1 (op 12) and shift left by 4 (op 13) of acc, filling with zeros: all clear O and C and update Z and S.
- R6: Shift right by 1 (op 14) and shift right by 4 (op 15) of acc, filling with zeros, clear O and C, update Z and set S to 1.
- R7: Decimal add from scratchpad (op 6) outputs the packed-BCD sum of acc and opnd modulo 100. C is set when the decimal sum is 100 or more. O follows R2 applied to the binary sum acc+opnd, and Z and S follow R3.
- R8: Decimal add from memory (op 7) gives the same result as op 6, clears O and C, and updates Z and S.
- R9: Clear (op 16) outputs 0, and no-op (op 0, and the unused codes 17 to 31) outputs acc. Neither changes O, Z, C or S.
- R10: int_dis_i clears the interrupt-control bit and otherwise int_en_i sets it; disable wins when both are high. Neither input changes any other flag, and the operation presented in the same cycle still updates its own flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| op_i | input | 5 | Operation code |
| int_en_i | input | 1 | Set interrupt-control bit |
| int_dis_i | input | 1 | Clear interrupt-control bit |
| result_o | output | 8 | Combinational result |
| status_o | output | 8 | Registered status word |

## Verification
Random operations and operands run back to back, so that each flag class follows every other class and stale flags would show. Operands are restricted to valid BCD digits for the decimal operations, and the decimal carry is checked apart from the binary overflow. Directed values probe the edges that separate the flag rules:
- 0x80+0x80 has a carry out and an overflow with a zero result.
- 0x7F+1 overflows with no carry.
- Decrementing 0x00 has no carry.
- Compare of equal values gives a zero difference while the result output stays the accumulator.
- 99+01 wraps to a decimal zero with carry.

Interrupt set, clear and simultaneous requests are mixed in, to show they leave the other flags alone.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   localparam int OP_W = 5;
   localparam int ST_W = 8;
   localparam int ST_S = 0;
   localparam int ST_C = 1;
   localparam int ST_Z = 2;
   localparam int ST_O = 3;
   localparam int ST_I = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_INC  = 5'd2,  OP_LNK  = 5'd3,
      OP_CMP  = 5'd4,  OP_DEC  = 5'd5,  OP_DADS = 5'd6,  OP_DADM = 5'd7,
      OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_COM  = 5'd11,
      OP_SL1  = 5'd12, OP_SL4  = 5'd13, OP_SR1  = 5'd14, OP_SR4  = 5'd15,
      OP_CLR  = 5'd16
   } alu_op_e;

   typedef enum logic [1:0] {
      FC_KEEP, FC_ARITH, FC_LOGIC, FC_RSHIFT
   } flag_cls_e;

   function automatic flag_cls_e cls_of(alu_op_e op);
      case (op)
         OP_ADD, OP_INC, OP_LNK, OP_CMP, OP_DEC, OP_DADS: return FC_ARITH;
         OP_DADM, OP_AND, OP_OR, OP_XOR, OP_COM,
         OP_SL1, OP_SL4:                                  return FC_LOGIC;
         OP_SR1, OP_SR4:                                  return FC_RSHIFT;
         default:                                         return FC_KEEP;
      endcase
   endfunction
endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         cin_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o,
   output logic         ovf_o
);
   logic [W-1:0] low;
   logic [1:0]   top;
   logic         c_msb;

   assign low    = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + W'(cin_i);
   assign c_msb  = low[W-1];
   assign top    = 2'(a_i[W-1]) + 2'(b_i[W-1]) + 2'(c_msb);
   assign sum_o  = {top[0], low[W-2:0]};
   assign cout_o = top[1];
   assign ovf_o  = top[1] ^ c_msb;
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   localparam int NDIG = W / 4;
   logic [NDIG:0] dc;
   assign dc[0] = 1'b0;

   for (genvar g = 0; g < NDIG; g++) begin : g_dig
      logic [4:0] raw;
      logic [4:0] fix;
      logic       adj;
      assign raw = {1'b0, a_i[4*g +: 4]} + {1'b0, b_i[4*g +: 4]} + 5'(dc[g]);
      assign adj = raw > 5'd9;
      assign fix = raw + (adj ? 5'd6 : 5'd0);
      assign sum_o[4*g +: 4] = fix[3:0];
      assign dc[g+1] = adj;
   end

   assign cout_o = dc[NDIG];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int W    = 8,
   parameter int SH_S = 1,
   parameter int SH_L = 4
) (
   input  alu_op_e      op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);
   if (SH_S < 1 || SH_L >= W || SH_S >= SH_L) begin : g_bad_shift
      $error("alu8_logic: shift distances out of range");
   end

   always_comb begin
      case (op_i)
         OP_AND:  res_o = a_i & b_i;
         OP_OR:   res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_COM:  res_o = ~a_i;
         OP_SL1:  res_o = a_i << SH_S;
         OP_SL4:  res_o = a_i << SH_L;
         OP_SR1:  res_o = a_i >> SH_S;
         OP_SR4:  res_o = a_i >> SH_L;
         default: res_o = a_i;
      endcase
   end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
   import alu8_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  flag_cls_e       cls_i,
   input  logic            o_i,
   input  logic            c_i,
   input  logic            z_i,
   input  logic            s_i,
   input  logic            ei_i,
   input  logic            di_i,
   output logic [ST_W-1:0] st_o
);
   logic [ST_I:0] fl_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fl_q <= '0;
      end else begin
         case (cls_i)
            FC_ARITH: begin
               fl_q[ST_O] <= o_i;  fl_q[ST_C] <= c_i;
               fl_q[ST_Z] <= z_i;  fl_q[ST_S] <= s_i;
            end
            FC_LOGIC: begin
               fl_q[ST_O] <= 1'b0; fl_q[ST_C] <= 1'b0;
               fl_q[ST_Z] <= z_i;  fl_q[ST_S] <= s_i;
            end
            FC_RSHIFT: begin
               fl_q[ST_O] <= 1'b0; fl_q[ST_C] <= 1'b0;
               fl_q[ST_Z] <= z_i;  fl_q[ST_S] <= 1'b1;
            end
            default: ;
         endcase
         if (di_i)      fl_q[ST_I] <= 1'b0;
         else if (ei_i) fl_q[ST_I] <= 1'b1;
      end
   end

   assign st_o = {{(ST_W-ST_I-1){1'b0}}, fl_q};
endmodule

// File: rtl/alu_status8.sv
module alu_status8
   import alu8_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SH_S   = 1,
   parameter int SH_L   = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [OP_W-1:0]   op_i,
   input  logic              int_en_i,
   input  logic              int_dis_i,
   output logic [DATA_W-1:0] result_o,
   output logic [ST_W-1:0]   status_o
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 8 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("alu_status8: DATA_W must be a multiple of 4 and at least 8");
   end

   alu_op_e           op;
   logic [DATA_W-1:0] ax, bx, add_sum, bcd_sum, log_res, flag_val;
   logic              cx, add_c, add_o, bcd_c, o_n, c_n, cur_c;

   assign op    = alu_op_e'(op_i);
   assign cur_c = status_o[ST_C];

   always_comb begin
      ax = acc_i;
      bx = opnd_i;
      cx = 1'b0;
      case (op)
         OP_INC: begin bx = '0; cx = 1'b1; end
         OP_LNK: begin bx = '0; cx = cur_c; end
         OP_CMP: begin ax = opnd_i; bx = ~acc_i; cx = 1'b1; end
         OP_DEC: begin ax = opnd_i; bx = '1; end
         default: ;
      endcase
   end

   alu8_adder #(.W(DATA_W)) u_add (
      .a_i(ax), .b_i(bx), .cin_i(cx),
      .sum_o(add_sum), .cout_o(add_c), .ovf_o(add_o)
   );

   alu8_bcd #(.W(DATA_W)) u_bcd (
      .a_i(acc_i), .b_i(opnd_i), .sum_o(bcd_sum), .cout_o(bcd_c)
   );

   alu8_logic #(.W(DATA_W), .SH_S(SH_S), .SH_L(SH_L)) u_log (
      .op_i(op), .a_i(acc_i), .b_i(opnd_i), .res_o(log_res)
   );

   always_comb begin
      case (op)
         OP_ADD, OP_INC, OP_LNK, OP_DEC:          result_o = add_sum;
         OP_DADS, OP_DADM:                        result_o = bcd_sum;
         OP_AND, OP_OR, OP_XOR, OP_COM,
         OP_SL1, OP_SL4, OP_SR1, OP_SR4:          result_o = log_res;
         OP_CLR:                                  result_o = '0;
         default:                                 result_o = acc_i;
      endcase
   end

   assign flag_val = (op == OP_CMP) ? add_sum : result_o;
   assign c_n      = (op == OP_DADS) ? bcd_c : add_c;
   assign o_n      = add_o;

   alu8_status u_st (
      .clk_i(clk_i), .rst_ni(rst_ni), .cls_i(cls_of(op)),
      .o_i(o_n), .c_i(c_n), .z_i(flag_val == '0), .s_i(~flag_val[MSB]),
      .ei_i(int_en_i), .di_i(int_dis_i), .st_o(status_o)
   );
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [DATA_W-1:0] acc_i,
   input logic [4:0]        op_i,
   input logic              int_en_i,
   input logic              int_dis_i,
   input logic [DATA_W-1:0] result_o,
   input logic [7:0]        status_o
);
   AST_SPARE_ZERO: assert property (@(posedge clk_i) status_o[7:5] == 3'b000); // R1
   AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |=> status_o == 8'h00); // R1
   AST_ADD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 5'd1 && result_o == '0) |=> status_o[2]); // R3
   AST_CMP_KEEPS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == 5'd4 |-> result_o == acc_i); // R4
   AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i >= 5'd8 && op_i <= 5'd13) |=> (!status_o[3] && !status_o[1])); // R5
   AST_RSHIFT_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 5'd14 || op_i == 5'd15) |=> status_o[0]); // R6
   AST_DADM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == 5'd7 |=> (!status_o[3] && !status_o[1])); // R8
   AST_KEEP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == 5'd0 || op_i >= 5'd16) |=> $stable(status_o[3:0])); // R9
   AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == 5'd16 |-> result_o == '0); // R9
   AST_INT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_en_i && !int_dis_i) |=> status_o[4]); // R10
   AST_INT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int_dis_i |=> !status_o[4]); // R10
endmodule

bind alu_status8 alu8_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .op_i(op_i),
   .int_en_i(int_en_i), .int_dis_i(int_dis_i),
   .result_o(result_o), .status_o(status_o)
);

// File: tb/sim_alu_status8.sv
`timescale 1ns/1ps
module sim_alu_status8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] acc = 8'h00, opnd = 8'h00;
   logic [4:0] op = 5'd0;
   logic       en = 1'b0, dis = 1'b0;
   logic [7:0] res, st;
   logic [7:0] exp_st = 8'h00;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   alu_status8 u0 (
      .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .opnd_i(opnd), .op_i(op),
      .int_en_i(en), .int_dis_i(dis), .result_o(res), .status_o(st)
   );

   function automatic string tag_of(input logic [4:0] o);
      case (o)
         5'd1, 5'd2, 5'd3:                        return "R2";
         5'd4, 5'd5:                              return "R4";
         5'd6:                                    return "R7";
         5'd7:                                    return "R8";
         5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13:  return "R5";
         5'd14, 5'd15:                            return "R6";
         default:                                 return "R9";
      endcase
   endfunction

   // returns {result, next status}
   function automatic logic [15:0] model(input logic [4:0] o, input logic [7:0] a, b, s,
                                         input logic e, d);
      int x, y, ci, full, low, dv;
      logic [7:0] r, fv, n;
      logic co, ov;
      int cls; // 0 keep, 1 arith, 2 logic, 3 right shift
      x = a; y = b; ci = 0; cls = 1; r = a;
      case (o)
         5'd2: begin y = 0; ci = 1; end
         5'd3: begin y = 0; ci = s[1]; end
         5'd4: begin x = b; y = (~a) & 8'hFF; ci = 1; end
         5'd5: begin x = b; y = 255; end
         default: ;
      endcase
      full = x + y + ci;
      low  = (x & 127) + (y & 127) + ci;
      co = full[8];
      ov = full[8] ^ low[7];
      r  = full[7:0];
      case (o)
         5'd4: r = a;
         5'd6, 5'd7: begin
            dv = (a >> 4) * 10 + (a & 15) + (b >> 4) * 10 + (b & 15);
            r = 8'(((dv % 100) / 10) * 16 + (dv % 10));
            co = dv >= 100;
            cls = (o == 5'd6) ? 1 : 2;
         end
         5'd8:  begin r = a & b;  cls = 2; end
         5'd9:  begin r = a | b;  cls = 2; end
         5'd10: begin r = a ^ b;  cls = 2; end
         5'd11: begin r = ~a;     cls = 2; end
         5'd12: begin r = a << 1; cls = 2; end
         5'd13: begin r = a << 4; cls = 2; end
         5'd14: begin r = a >> 1; cls = 3; end
         5'd15: begin r = a >> 4; cls = 3; end
         5'd16: begin r = 8'h00;  cls = 0; end
         5'd1, 5'd2, 5'd3, 5'd5: ;
         default: begin r = a; cls = 0; end
      endcase
      fv = (o == 5'd4) ? full[7:0] : r;
      n = s;
      if (cls != 0) begin
         n[2] = (fv == 8'h00);
         n[0] = (cls == 3) ? 1'b1 : ~fv[7];
         n[1] = (cls == 1) ? co : 1'b0;
         n[3] = (cls == 1) ? ov : 1'b0;
      end
      if (d) n[4] = 1'b0;
      else if (e) n[4] = 1'b1;
      return {r, n};
   endfunction

   task automatic check(input string tag, input string what, input logic [7:0] act, expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, expv);
      end
   endtask

   task automatic do_op(input logic [4:0] o, input logic [7:0] a, b, input logic e, d);
      logic [15:0] m;
      @(negedge clk);
      op = o; acc = a; opnd = b; en = e; dis = d;
      #1;
      m = model(o, a, b, exp_st, e, d);
      check(tag_of(o), "result", res, m[15:8]);
      @(posedge clk);
      #1;
      check(tag_of(o), "status", st, m[7:0]);
      check("R3", "zero/sign", {6'b0, st[2], st[0]}, {6'b0, m[2], m[0]});
      check("R10", "int bit", {7'b0, st[4]}, {7'b0, m[4]});
      check("R1", "spare bits", {5'b0, st[7:5]}, 8'h00);
      exp_st = st === m[7:0] ? m[7:0] : m[7:0];
   endtask

   function automatic logic [7:0] bcd_rand();
      return {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 check("R1", "reset status", st, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      exp_st = 8'h00;
      // directed corners
      do_op(5'd1,  8'h80, 8'h80, 1'b0, 1'b0); // carry and overflow, zero
      do_op(5'd2,  8'h7F, 8'h00, 1'b0, 1'b0); // overflow only
      do_op(5'd1,  8'hFF, 8'h01, 1'b0, 1'b0); // carry set
      do_op(5'd3,  8'h10, 8'h00, 1'b0, 1'b0); // link uses stored carry
      do_op(5'd4,  8'h05, 8'h05, 1'b0, 1'b0); // compare equal
      do_op(5'd4,  8'h09, 8'h03, 1'b0, 1'b0); // compare acc greater
      do_op(5'd5,  8'h00, 8'h00, 1'b0, 1'b0); // decrement zero
      do_op(5'd6,  8'h99, 8'h01, 1'b1, 1'b0); // decimal wrap with carry
      do_op(5'd7,  8'h99, 8'h01, 1'b0, 1'b0); // decimal from memory
      do_op(5'd14, 8'h01, 8'h00, 1'b0, 1'b0); // shift right to zero
      do_op(5'd15, 8'hF0, 8'h00, 1'b0, 1'b0);
      do_op(5'd13, 8'h0F, 8'h00, 1'b0, 1'b0);
      do_op(5'd11, 8'hFF, 8'h00, 1'b0, 1'b0);
      do_op(5'd1,  8'h80, 8'h80, 1'b0, 1'b0);
      do_op(5'd16, 8'h55, 8'h00, 1'b0, 1'b1); // clear keeps flags
      do_op(5'd0,  8'h3C, 8'h00, 1'b1, 1'b1); // both: disable wins
      do_op(5'd0,  8'h3C, 8'h00, 1'b1, 1'b0);
      do_op(5'd21, 8'hA5, 8'h11, 1'b0, 1'b0); // unused code
      // constrained random
      for (int i = 0; i < 600; i++) begin
         logic [4:0] o;
         logic [7:0] a, b;
         o = 5'($urandom_range(0, 17));
         if (o == 5'd6 || o == 5'd7) begin
            a = bcd_rand(); b = bcd_rand();
         end else begin
            a = 8'($urandom); b = 8'($urandom);
         end
         do_op(o, a, b, ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule